// File: doc/BRIEF.md
# Auto-Reload Display Clock Divider

This block turns a stream of single-cycle count-enable pulses into a slow square wave for a display driver. A down counter steps once per selected pulse. When a pulse arrives while the counter already holds zero, that pulse counts as the underflow: the counter refills from a reload register and carries on. Each underflow flips an output flip-flop, so the output is the underflow rate divided by two. With a reload value n, the pulse rate is divided by n+1, and the output period is 2(n+1) selected pulses.

Software-side logic first stops the divider. It then issues one load strobe, which writes the same value into the counter and the reload register. It picks one of two pulse inputs with a select bit and raises the run bit. The counter value is not visible at the ports. A load attempted while the divider runs has no effect and raises an error pulse for one cycle.

A two-state machine controls the block. ST_IDLE is the reset state. In ST_IDLE counting is frozen and loads are accepted. ST_RUN lets selected pulses decrement the counter and rejects loads. Transition T_START (ST_IDLE to ST_RUN) fires on a clock edge where `run_i` is 1. Transition T_STOP (ST_RUN to ST_IDLE) fires on an edge where `run_i` is 0.

Top module: `dispclk_divider`

## Requirements
- R1: While reset is asserted and immediately after it, `clk_out_o` is 0 and `load_err_o` is 0. The counter and reload register hold 0 and the state is ST_IDLE.
- R2: A `load_i` strobe sampled in ST_IDLE writes `load_val_i` into both the counter and the reload register on that edge.
- R3: `src_sel_i` = 0 selects `src_a_en_i` as the count pulse, and `src_sel_i` = 1 selects `src_b_en_i`. The unselected input has no effect on the output.
- R4: The state follows `run_i` with one cycle of delay (T_START, T_STOP). Pulses sampled while the state is ST_IDLE do not change the counter or the output.
- R5: In ST_RUN, a selected pulse decrements a nonzero counter. A selected pulse that finds the counter at 0 is an underflow, and the counter reloads from the reload register. Underflows therefore repeat every n+1 selected pulses, for n from 0 to 15.
- R6: `clk_out_o` inverts on the clock edge that samples an underflow pulse, and at no other time. Its period is 2(n+1) selected pulses.
- R7: A `load_i` strobe sampled in ST_RUN changes neither the counter nor the reload register. `load_err_o` is 1 during the following cycle, once per rejected strobe cycle, and 0 otherwise.
- R8: Across T_STOP and a later T_START, the counter value and the `clk_out_o` level are held. Counting resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for counter and reload register |
| load_val_i | input | CNT_W | Value to load |
| src_sel_i | input | 1 | Count source select (0: A, 1: B) |
| run_i | input | 1 | Run bit; 1 counts, 0 stops |
| src_a_en_i | input | 1 | Count-enable pulse, source A |
| src_b_en_i | input | 1 | Count-enable pulse, source B |
| clk_out_o | output | 1 | Divided square-wave output |
| load_err_o | output | 1 | One-cycle pulse for a load rejected while running |

## Verification
The bench uses the default `CNT_W` = 4. This makes the full reload range reachable, including the boundaries n = 0 (the output flips on every selected pulse) and n = 15 (sixteen pulses per underflow). The reference model runs on irregular, pseudo-random pulse patterns on both sources, so the unselected source is active at the same time. The bench covers stopping mid-count, a load rejected while running followed by resuming, and pulses sent while stopped.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
    import dcd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic load_i,
    output logic run_act_o,
    output logic load_ok_o,
    output logic load_err_o
);
    run_state_e state_q, state_d;
    logic       err_q;

    // next-state: T_START / T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i)  state_d = ST_RUN;
            ST_RUN:  if (!run_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q <= 1'b0;
        else         err_q <= load_i && (state_q == ST_RUN);
    end

    // outputs
    always_comb begin
        run_act_o  = 1'b0;
        load_ok_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: load_ok_o = load_i;
            ST_RUN:  run_act_o = 1'b1;
            default: ;
        endcase
        load_err_o = err_q;
    end

    AST_ERR_ONLY_AFTER_RUN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_err_o |-> $past(load_i) && $past(run_act_o)); // R7
    AST_RUN_FOLLOWS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> run_act_o); // R4
endmodule

// File: rtl/dcd_counter.sv
module dcd_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cnt_en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             uf_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, rld_q;
    logic             at_zero;

    assign at_zero = (cnt_q == ZERO);
    assign uf_o    = cnt_en_i && at_zero;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= ZERO;
            rld_q <= ZERO;
        end else if (load_i) begin
            cnt_q <= load_val_i;
            rld_q <= load_val_i;
        end else if (cnt_en_i) begin
            cnt_q <= at_zero ? rld_q : cnt_q - ONE;
        end
    end

    AST_LOAD_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == rld_q)); // R2
    AST_RELOAD_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_en_i && !load_i && at_zero) |=> (cnt_q == $past(rld_q))); // R5
    AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_en_i && !load_i && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE)); // R5
    AST_HOLD_WITHOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_en_i && !load_i) |=> $stable(cnt_q) && $stable(rld_q)); // R4
endmodule

// File: rtl/dcd_toggle.sv
module dcd_toggle (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic uf_i,
    input  logic run_act_i,
    output logic out_o
);
    logic out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   out_q <= 1'b0;
        else if (uf_i) out_q <= ~out_q;
    end

    assign out_o = out_q;

    AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_act_i |=> $stable(out_o)); // R8
    AST_FLIP_ON_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uf_i |=> (out_o != $past(out_o))); // R6
endmodule

// File: rtl/dispclk_divider.sv
module dispclk_divider #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             src_sel_i,
    input  logic             run_i,
    input  logic             src_a_en_i,
    input  logic             src_b_en_i,
    output logic             clk_out_o,
    output logic             load_err_o
);
    logic run_act, load_ok, pulse, cnt_en, uf;

    assign pulse  = src_sel_i ? src_b_en_i : src_a_en_i;
    assign cnt_en = run_act && pulse;

    dcd_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .load_i     (load_i),
        .run_act_o  (run_act),
        .load_ok_o  (load_ok),
        .load_err_o (load_err_o)
    );

    dcd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_en_i   (cnt_en),
        .load_i     (load_ok),
        .load_val_i (load_val_i),
        .uf_o       (uf)
    );

    dcd_toggle u_tog (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .uf_i      (uf),
        .run_act_i (run_act),
        .out_o     (clk_out_o)
    );

    AST_NO_LOAD_WHILE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && run_act) |=> load_err_o); // R7
endmodule

// File: tb/dispclk_divider_tb_top.sv
module dispclk_divider_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] val = '0;
    logic         sel = 1'b0;
    logic         run = 1'b0;
    logic         sa = 1'b0;
    logic         sb = 1'b0;
    logic         clk_out, err;

    int    total = 0, bad = 0;
    string cur_req = "R1";
    int    lfsr = 32'h1ACE;
    bit    done = 0;

    // reference model
    bit m_run, m_out, m_err;
    int m_cnt, m_rld;

    always #2 clk = ~clk;

    dispclk_divider #(.CNT_W(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_val_i(val),
        .src_sel_i(sel), .run_i(run), .src_a_en_i(sa), .src_b_en_i(sb),
        .clk_out_o(clk_out), .load_err_o(err)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_out = 0; m_err = 0; m_cnt = 0; m_rld = 0;
        end else begin
            bit p;
            p = sel ? sb : sa;
            if (m_run && p) begin
                if (m_cnt == 0) begin m_cnt = m_rld; m_out = !m_out; end
                else m_cnt = m_cnt - 1;
            end
            m_err = load && m_run;
            if (load && !m_run) begin m_cnt = int'(val); m_rld = int'(val); end
            m_run = run;
        end
    end

    task automatic check_now();
        total++;
        if (clk_out !== m_out) begin
            bad++;
            $display("FAIL %s clk_out act=%b exp=%b t=%0t", cur_req, clk_out, m_out, $time);
        end
        total++;
        if (err !== m_err) begin
            bad++;
            $display("FAIL %s load_err act=%b exp=%b t=%0t", cur_req, err, m_err, $time);
        end
    endtask

    function automatic bit rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        return lfsr[0] ^ lfsr[3];
    endfunction

    // one clock: check at negedge, then drive next inputs
    task automatic cyc(input bit a, input bit b);
        @(negedge clk);
        check_now();
        load = 1'b0;
        sa = a;
        sb = b;
    endtask

    task automatic do_load(input int v);
        @(negedge clk);
        check_now();
        sa = 0; sb = 0;
        load = 1'b1;
        val = W'(v);
    endtask

    task automatic run_pattern(input int n, input bit dense);
        for (int i = 0; i < n; i++) begin
            if (dense) cyc(1'b1, 1'b1);
            else cyc(rnd(), rnd());
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        check_now();
        rst_n = 1'b1;
        cyc(0, 0);
        cyc(0, 0);

        // R2, R5, R6: load 3, source A dense
        cur_req = "R2";
        do_load(3);
        cyc(0, 0);
        cur_req = "R5";
        run = 1'b1;
        sel = 1'b0;
        run_pattern(20, 1'b1);
        cur_req = "R6";
        run_pattern(30, 1'b0);

        // R3: source B pulses while A selected, then switch
        cur_req = "R3";
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1);
        sel = 1'b1;
        for (int i = 0; i < 20; i++) cyc(1'b0, rnd());
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0);

        // R7: load while running
        cur_req = "R7";
        do_load(9);
        do_load(1);
        cyc(1, 1);
        run_pattern(20, 1'b1);

        // R4, R8: stop mid-count, pulses while stopped, resume
        cur_req = "R8";
        cyc(1, 1);
        run = 1'b0;
        cur_req = "R4";
        run_pattern(15, 1'b1);
        cur_req = "R8";
        run = 1'b1;
        run_pattern(25, 1'b0);

        // R5 boundary n=0 and n=15
        cur_req = "R5";
        run = 1'b0;
        cyc(0, 0);
        cyc(0, 0);
        do_load(0);
        cyc(0, 0);
        run = 1'b1;
        run_pattern(12, 1'b1);
        run = 1'b0;
        cyc(0, 0);
        cyc(0, 0);
        do_load(15);
        cyc(0, 0);
        run = 1'b1;
        cur_req = "R6";
        run_pattern(70, 1'b1);
        run_pattern(60, 1'b0);
        cyc(0, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule